// File: doc/BRIEF.md
# Periodic Wakeup Countdown Timer

This block is an auto-reloading down-counter that counts a once-per-second tick and raises a sticky wakeup flag each time a programmed number of ticks has gone by. After each expiry it reloads and runs again, so the flag comes back at a fixed period until the timer is switched off. A separate interrupt output follows the flag while the interrupt enable is set.

The period comes from a 16-bit reload value, which holds the delay minus one, and a 3-bit clock-select code. The code `3'b110` adds 65536 to the reload, so a single block covers delays from 1 to 131072 seconds. The reload and the select code can only be changed while the timer is stopped. A write-ready status output reports when that is allowed. Because the run enable passes through a two-stage synchroniser, the write-ready output answers a change of the enable two clock cycles after the change.

Top module: `wakeup_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cfg_ready` is 1, `wake_flag` is 0 and `wake_irq` is 0.
- R2: With select code `3'b100`, once the timer is running the first expiry comes after reload+1 ticks. A tick is a clock cycle with `tick_1hz` high. `wake_flag` reads 1 in the cycle after the tick that expires the count.
- R3: With select code `3'b110`, the period is reload+65537 ticks.
- R4: After an expiry the counter reloads by itself, and the next expiry comes after another full period without any restart.
- R5: `cfg_ready` goes to 0 two clock edges after `run_en` is set, and returns to 1 two clock edges after `run_en` is cleared. The counter is loaded from the held configuration on the edge where `cfg_ready` falls.
- R6: A configuration write (`cfg_we` high) made while `cfg_ready` is 0 is ignored. The period in force, now and after a later restart, is unchanged.
- R7: While the timer is stopped (`cfg_ready` is 1), ticks are ignored and `wake_flag` does not rise.
- R8: A one-cycle pulse on `flag_clr` clears `wake_flag`. If an expiry and `flag_clr` fall on the same edge, the expiry wins and the flag stays 1.
- R9: `wake_irq` is 1 exactly when `wake_flag` is 1 and `irq_en` is 1.
- R10: Every select code other than `3'b110` (for example `3'b000` or `3'b111`) counts the tick directly, with no offset added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable of the timer |
| irq_en | input | 1 | Interrupt enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reload | input | 16 | Reload value (delay minus one) |
| cfg_sel | input | 3 | Clock-select code |
| flag_clr | input | 1 | Clear pulse for the wakeup flag |
| tick_1hz | input | 1 | One-cycle count tick |
| cfg_ready | output | 1 | Configuration may be written |
| wake_flag | output | 1 | Sticky expiry flag |
| wake_irq | output | 1 | Interrupt request |

## Verification
The bench measures expiry periods for reload values of 0 and above and for several select codes, including the 65536 offset. A counter that is off by one, or that applies the offset to the wrong code, would give a tick count one away from the expected value or 65536 away from it. It writes a new configuration while the timer runs, then restarts the timer. A design that did not lock its registers would show the new period. It also times the falling and rising edges of `cfg_ready` to the cycle. It drives an expiry and a flag clear on the same edge, where a design with the wrong priority would drop the flag. Finally it feeds ticks to a stopped timer, which a design that ignored the enable would expire on.

// File: rtl/wut_pkg.sv
package wut_pkg;

    localparam int RELOAD_W = 16;
    localparam int SEL_W    = 3;
    localparam int CNT_W    = RELOAD_W + 1;

    localparam logic [SEL_W-1:0] SEL_DIRECT = 3'b100;
    localparam logic [SEL_W-1:0] SEL_EXTEND = 3'b110;

    typedef struct packed {
        logic [SEL_W-1:0]    sel;
        logic [RELOAD_W-1:0] reload;
    } wut_cfg_t;

    // Effective start value of the countdown: the offset bit is set only by the extend code.
    function automatic logic [CNT_W-1:0] eff_reload(input wut_cfg_t c);
        logic ext;
        ext = (c.sel == SEL_EXTEND);
        return {ext, c.reload};
    endfunction

endpackage

// File: rtl/wut_enable_sync.sv
module wut_enable_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic en_sync,
    output logic en_rise
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[0] <= 1'b0;
                    else     pipe_q[0] <= en_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[i] <= 1'b0;
                    else     pipe_q[i] <= pipe_q[i-1];
                end
            end
        end
    endgenerate

    assign en_sync = pipe_q[STAGES-1];
    assign en_rise = pipe_q[STAGES-2] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/wut_cfg_reg.sv
module wut_cfg_reg
    import wut_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic     unlocked,
    input  wut_cfg_t cfg_in,
    output wut_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)                cfg_q <= '{sel: SEL_DIRECT, reload: '0};
        else if (we && unlocked) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/wut_counter.sv
module wut_counter
    import wut_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     load,
    input  logic     tick,
    input  wut_cfg_t cfg,
    output logic     expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] start_val;

    assign start_val = eff_reload(cfg);
    assign expire    = active && tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= start_val;
        end else if (active && tick) begin
            if (cnt_q == '0) cnt_q <= start_val;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wut_status.sv
module wut_status (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (expire) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
    import wut_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic                irq_en,
    input  logic                cfg_we,
    input  logic [RELOAD_W-1:0] cfg_reload,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic                flag_clr,
    input  logic                tick_1hz,
    output logic                cfg_ready,
    output logic                wake_flag,
    output logic                wake_irq
);
    logic     running;
    logic     start_pulse;
    logic     expire;
    wut_cfg_t cfg_wdata;
    wut_cfg_t cfg_q;

    assign cfg_wdata = '{sel: cfg_sel, reload: cfg_reload};

    wut_enable_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .en_in   (run_en),
        .en_sync (running),
        .en_rise (start_pulse)
    );

    assign cfg_ready = ~running;

    wut_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .unlocked (cfg_ready),
        .cfg_in   (cfg_wdata),
        .cfg_q    (cfg_q)
    );

    wut_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (running),
        .load   (start_pulse),
        .tick   (tick_1hz),
        .cfg    (cfg_q),
        .expire (expire)
    );

    wut_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .clr    (flag_clr),
        .flag   (wake_flag)
    );

    assign wake_irq = wake_flag & irq_en;
endmodule

// File: rtl/wakeup_timer_chk.sv
module wakeup_timer_chk
    import wut_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     run_en,
    input logic     irq_en,
    input logic     flag_clr,
    input logic     tick_1hz,
    input logic     cfg_ready,
    input logic     wake_flag,
    input logic     wake_irq,
    input logic     expire,
    input wut_cfg_t cfg_q
);
    AST_READY_LOW_WHEN_RUN: assert property (@(posedge clk) disable iff (rst)
        (run_en && $past(run_en) && !$past(rst)) |=> !cfg_ready); // R5

    AST_READY_HIGH_WHEN_STOP: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !$past(run_en)) |=> cfg_ready); // R5

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_ready)) |-> $stable(cfg_q)); // R6

    AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> ($past(tick_1hz) && !$past(cfg_ready))); // R7

    AST_FLAG_FALL_ON_CLR: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_flag) |-> $past(flag_clr)); // R8

    AST_EXPIRY_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        expire |=> wake_flag); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> (wake_flag && irq_en)); // R9
endmodule

bind wakeup_timer wakeup_timer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .tick_1hz  (tick_1hz),
    .cfg_ready (cfg_ready),
    .wake_flag (wake_flag),
    .wake_irq  (wake_irq),
    .expire    (expire),
    .cfg_q     (cfg_q)
);

// File: tb/wakeup_timer_tb.sv
module wakeup_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        run_en, irq_en, cfg_we, flag_clr, tick_1hz;
    logic [15:0] cfg_reload;
    logic [2:0]  cfg_sel;
    logic        cfg_ready, wake_flag, wake_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    wakeup_timer dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .irq_en(irq_en),
        .cfg_we(cfg_we), .cfg_reload(cfg_reload), .cfg_sel(cfg_sel),
        .flag_clr(flag_clr), .tick_1hz(tick_1hz),
        .cfg_ready(cfg_ready), .wake_flag(wake_flag), .wake_irq(wake_irq)
    );

    // reload[39:24], sel[22:20], expected period in ticks [19:0]
    localparam int NVEC = 5;
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd0, 1'b0, 3'b100, 20'd1},
        {16'd3, 1'b0, 3'b100, 20'd4},
        {16'd6, 1'b0, 3'b000, 20'd7},
        {16'd1, 1'b0, 3'b111, 20'd2},
        {16'd2, 1'b0, 3'b110, 20'd65539}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic stop_timer();
        run_en = 1'b0;
        while (!cfg_ready) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [15:0] rl, input logic [2:0] sl);
        cfg_we = 1'b1; cfg_reload = rl; cfg_sel = sl;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_timer();
        run_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic count_ticks(output int n);
        n = 0;
        tick_1hz = 1'b1;
        while (n < 70000) begin
            @(negedge clk);
            n++;
            if (wake_flag) break;
        end
        tick_1hz = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; run_en = 0; irq_en = 0; cfg_we = 0; flag_clr = 0; tick_1hz = 0;
        cfg_reload = '0; cfg_sel = 3'b100;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", int'(cfg_ready), 1);
        chk("R1 flag in reset", int'(wake_flag), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", int'(cfg_ready), 1);
        chk("R1 flag after reset", int'(wake_flag), 0);
        chk("R1 irq after reset", int'(wake_irq), 0);

        // Table of configurations: R2 R3 R4 R10
        for (int i = 0; i < NVEC; i++) begin
            stop_timer();
            write_cfg(VEC[i][39:24], VEC[i][22:20]);
            clear_flag();
            start_timer();
            count_ticks(n);
            chk($sformatf("R2/R3/R10 period vec %0d", i), n, int'(VEC[i][19:0]));
            if (VEC[i][19:0] < 100) begin
                clear_flag();
                count_ticks(n);
                chk($sformatf("R4 reload period vec %0d", i), n, int'(VEC[i][19:0]));
            end
        end

        // R5 timing of cfg_ready
        stop_timer();
        run_en = 1'b1;
        @(negedge clk);
        chk("R5 ready after one edge", int'(cfg_ready), 1);
        @(negedge clk);
        chk("R5 ready low after two edges", int'(cfg_ready), 0);
        run_en = 1'b0;
        @(negedge clk);
        chk("R5 ready still low after one edge", int'(cfg_ready), 0);
        @(negedge clk);
        chk("R5 ready high after two edges", int'(cfg_ready), 1);

        // R6 writes while running are ignored
        write_cfg(16'd4, 3'b100);
        clear_flag();
        start_timer();
        write_cfg(16'd0, 3'b110);
        count_ticks(n);
        chk("R6 period unchanged after locked write", n, 5);
        stop_timer();
        clear_flag();
        start_timer();
        count_ticks(n);
        chk("R6 period unchanged after restart", n, 5);

        // R7 ticks ignored while stopped
        stop_timer();
        write_cfg(16'd0, 3'b100);
        clear_flag();
        tick_1hz = 1'b1;
        repeat (8) @(negedge clk);
        tick_1hz = 1'b0;
        chk("R7 no flag while stopped", int'(wake_flag), 0);

        // R8 clear and expiry on the same edge
        start_timer();
        count_ticks(n);
        chk("R8 setup expiry", n, 1);
        tick_1hz = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0; flag_clr = 1'b0;
        chk("R8 expiry wins over clear", int'(wake_flag), 1);
        clear_flag();
        chk("R8 clear pulse", int'(wake_flag), 0);

        // R9 interrupt gating
        irq_en = 1'b1;
        #1 chk("R9 irq low without flag", int'(wake_irq), 0);
        count_ticks(n);
        #1 chk("R9 irq with flag and enable", int'(wake_irq), 1);
        irq_en = 1'b0;
        #1 chk("R9 irq masked", int'(wake_irq), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule